// File: doc/BRIEF.md
# Power-State Reset Sequencer

This block is the top-level state machine of a power-management device. It moves between five power states: no supply, waiting for switch-on/off, switch-on sequencing, active and sleep. It also gathers every cause that can restart or shut down the system. One cause is a loss of both energy sources. Another is a falling edge on an active-low warm-restart pin. The others are a software cold-restart strobe, a power key held for a fixed number of seconds, a watchdog expiry and a thermal-shutdown flag. Each cause takes its own path through the state machine.

The block drives three outputs. The first is an active-low reset to the host processor. The second is a delayed active-low reset to the charger logic. The third is a sticky per-cause record of the last turn-off, which software clears by writing ones. The supply ramp itself is stood in for by a counter that ends a fixed number of cycles after sequencing begins.

A warm restart re-runs the start-up sequence and leaves the supplies on. It pulses a re-initialise strobe for the power and charger register groups. For each resource it reports whether the voltage setting must be reloaded from default, or kept, according to that resource's keep bit. An optional gate can hold the host reset until the slow-clock oscillator reports stable.

Top module: `pwr_rst_seq`

## Requirements
- R1: When `main_batt_low` and `bkup_batt_low` are both high at a clock edge, `pwr_state` becomes 0 (no supply) at that edge and stays 0 while both are high. `host_rst_n` is low in that state. A single low battery has no effect.
- R2: When the supply-loss condition clears in state 0, `pwr_state` becomes 2 (sequencing) at the next edge. It becomes 3 (active) exactly SEQ_CYC edges after entering state 2.
- R3: `chg_rst_n` is low from the cycle after the block enters state 0. It is released on the (CHG_STEP+1)-th edge after state 2 is entered from state 0, which is before the host reset is released.
- R4: A `sw_cold_rst` pulse in states 2, 3 or 4 moves the block to state 1 (wait on/off). The next edge moves it to state 2 with no other input, and the normal sequence then brings it back to state 3.
- R5: With `key_held` high, KEY_SEC pulses of `tick_1hz` force state 1 on the second edge after the last tick. Releasing the key restarts the count.
- R6: A `wdog_expired` or `therm_shut` pulse in states 2, 3 or 4 forces state 1. The block leaves state 1 only on `on_req` or a pending software restart. Shutdown causes arriving in state 0 or 1 are neither acted on nor recorded.
- R7: `turnoff_stat` bit 0 records the key cause, bit 1 the watchdog, bit 2 thermal and bit 3 software. Bits are set when their cause forces a shutdown, and all causes of one cycle are recorded. Bits stay set until a one in the same position of `stat_clr`, and a set wins over a clear in the same cycle.
- R8: A falling edge of `warm_req_n` while `host_rst_n` is high moves the block to state 2 at that edge. In the following cycle `warm_reinit` is high for one cycle and `vsel_reload` equals the inverse of `keep_vsel`. `turnoff_stat` and `chg_rst_n` are unchanged.
- R9: A falling edge of `warm_req_n` while `host_rst_n` is low (during sequencing, or while held for the oscillator) is ignored. The state does not change and `warm_reinit` stays low.
- R10: `host_rst_n` is high only in states 3 and 4. While `osc_gate_en` is high it is also held low until `osc_stable` is high.
- R11: `sleep_req` in state 3 moves the block to state 4 (sleep), and `wake_req` in state 4 moves it back to state 3. The host reset stays released across both moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous flop reset, active low |
| main_batt_low | input | 1 | Main battery below threshold |
| bkup_batt_low | input | 1 | Backup battery below threshold |
| on_req | input | 1 | Switch-on request out of the wait state |
| sw_cold_rst | input | 1 | Software cold-restart strobe |
| key_held | input | 1 | Power key pressed (level) |
| tick_1hz | input | 1 | One-second enable pulse |
| wdog_expired | input | 1 | Watchdog expiry pulse |
| therm_shut | input | 1 | Thermal shutdown flag |
| warm_req_n | input | 1 | Warm-restart request, active low, edge sensed |
| sleep_req | input | 1 | Request to enter sleep |
| wake_req | input | 1 | Request to leave sleep |
| osc_stable | input | 1 | Slow-clock oscillator stable |
| osc_gate_en | input | 1 | Hold host reset until oscillator is stable |
| keep_vsel | input | N_RES | Per-resource keep-voltage bit on warm restart |
| stat_clr | input | 4 | Write-one-to-clear strobe for the turn-off record |
| host_rst_n | output | 1 | Host reset, active low |
| chg_rst_n | output | 1 | Delayed charger reset, active low |
| warm_reinit | output | 1 | Re-initialise pulse for the power and charger register groups |
| vsel_reload | output | N_RES | Per-resource reload-default pulse on warm restart |
| pwr_state | output | 3 | Current power state |
| turnoff_stat | output | 4 | Sticky last-turn-off causes |

## Verification
Several properties are checked on every cycle. The host reset can never be released outside active or sleep, or while the oscillator gate blocks it. A supply loss always lands in the no-supply state, and the charger reset is held there. Turn-off record bits never drop without a clear. A warm re-initialise pulse only follows a released host reset, and reload pulses never appear without it. Only the directed scenarios can show the exact sequencing lengths, the key-timer restart on release, the automatic switch-on after a software restart, and the keep/reload split across resources.

// File: rtl/pwr_rst_pkg.sv
package pwr_rst_pkg;
   typedef enum logic [2:0] {
      ST_NO_SUPPLY  = 3'd0,
      ST_WAIT_ONOFF = 3'd1,
      ST_SEQ_ON     = 3'd2,
      ST_ACTIVE     = 3'd3,
      ST_SLEEP      = 3'd4
   } pwr_state_e;

   localparam int CAUSE_W = 4;
   localparam int C_KEY   = 0;
   localparam int C_WDOG  = 1;
   localparam int C_THERM = 2;
   localparam int C_SOFT  = 3;
endpackage

// File: rtl/pwr_key_hold.sv
module pwr_key_hold #(
   parameter int KEY_SEC = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic key_held,
   input  logic tick,
   output logic long_hit
);
   localparam int CW = $clog2(KEY_SEC + 1);
   localparam logic [CW-1:0] LIM  = CW'(KEY_SEC);
   localparam logic [CW-1:0] PREV = CW'(KEY_SEC - 1);

   logic [CW-1:0] sec_q;
   logic          hit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q <= '0;
         hit_q <= 1'b0;
      end else begin
         hit_q <= key_held && tick && (sec_q == PREV);
         if (!key_held)
            sec_q <= '0;
         else if (tick && (sec_q != LIM))
            sec_q <= sec_q + 1'b1;
      end
   end

   assign long_hit = hit_q;
endmodule

// File: rtl/pwr_seq_stub.sv
module pwr_seq_stub #(
   parameter int SEQ_CYC  = 8,
   parameter int CHG_STEP = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done,
   output logic chg_hit
);
   localparam int CW = $clog2(SEQ_CYC);
   localparam logic [CW-1:0] LAST = CW'(SEQ_CYC - 1);
   localparam logic [CW-1:0] CHGP = CW'(CHG_STEP);

   logic [CW-1:0] step_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         step_q <= '0;
      else if (!run)
         step_q <= '0;
      else if (step_q != LAST)
         step_q <= step_q + 1'b1;
   end

   assign done    = run && (step_q == LAST);
   assign chg_hit = run && (step_q == CHGP);
endmodule

// File: rtl/pwr_cause_stat.sv
module pwr_cause_stat #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_v,
   input  logic [W-1:0] clr_v,
   output logic [W-1:0] stat
);
   logic [W-1:0] bit_q;

   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bit_q[i] <= 1'b0;
         else if (set_v[i])
            bit_q[i] <= 1'b1;
         else if (clr_v[i])
            bit_q[i] <= 1'b0;
      end
   end

   assign stat = bit_q;
endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq
   import pwr_rst_pkg::*;
#(
   parameter int SEQ_CYC      = 8,
   parameter int CHG_STEP     = 3,
   parameter int KEY_SEC      = 10,
   parameter int N_RES        = 4,
   parameter bit HAS_OSC_GATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             main_batt_low,
   input  logic             bkup_batt_low,
   input  logic             on_req,
   input  logic             sw_cold_rst,
   input  logic             key_held,
   input  logic             tick_1hz,
   input  logic             wdog_expired,
   input  logic             therm_shut,
   input  logic             warm_req_n,
   input  logic             sleep_req,
   input  logic             wake_req,
   input  logic             osc_stable,
   input  logic             osc_gate_en,
   input  logic [N_RES-1:0] keep_vsel,
   input  logic [3:0]       stat_clr,
   output logic             host_rst_n,
   output logic             chg_rst_n,
   output logic             warm_reinit,
   output logic [N_RES-1:0] vsel_reload,
   output logic [2:0]       pwr_state,
   output logic [3:0]       turnoff_stat
);
   if (SEQ_CYC < 2) begin : g_bad_seq
      $error("SEQ_CYC must be at least 2");
   end
   if (CHG_STEP >= SEQ_CYC - 1) begin : g_bad_chg
      $error("CHG_STEP must fall before the last sequencing cycle");
   end
   if (KEY_SEC < 1) begin : g_bad_key
      $error("KEY_SEC must be at least 1");
   end
   if (N_RES < 1) begin : g_bad_res
      $error("N_RES must be at least 1");
   end

   pwr_state_e         state_q, state_d;
   logic               restart_q;
   logic               warm_prev_q;
   logic               chg_q;
   logic               reinit_q;
   logic [N_RES-1:0]   reload_q;
   logic               long_hit, seq_done, chg_hit;
   logic               supply_lost, in_run, live, osc_ok;
   logic               warm_fall, warm_take;
   logic [CAUSE_W-1:0] cause_v, down_v;

   pwr_key_hold #(.KEY_SEC(KEY_SEC)) u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_held (key_held),
      .tick     (tick_1hz),
      .long_hit (long_hit)
   );

   pwr_seq_stub #(.SEQ_CYC(SEQ_CYC), .CHG_STEP(CHG_STEP)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state_q == ST_SEQ_ON),
      .done    (seq_done),
      .chg_hit (chg_hit)
   );

   pwr_cause_stat #(.W(CAUSE_W)) u_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .set_v (down_v),
      .clr_v (stat_clr),
      .stat  (turnoff_stat)
   );

   if (HAS_OSC_GATE) begin : g_osc_gate
      assign osc_ok = !osc_gate_en || osc_stable;
   end else begin : g_no_osc_gate
      assign osc_ok = 1'b1;
   end

   assign supply_lost = main_batt_low && bkup_batt_low;
   assign in_run      = (state_q == ST_ACTIVE) || (state_q == ST_SLEEP);
   assign live        = in_run || (state_q == ST_SEQ_ON);

   always_comb begin
      cause_v          = '0;
      cause_v[C_KEY]   = long_hit;
      cause_v[C_WDOG]  = wdog_expired;
      cause_v[C_THERM] = therm_shut;
      cause_v[C_SOFT]  = sw_cold_rst;
   end

   assign down_v     = (live && !supply_lost) ? cause_v : '0;
   assign host_rst_n = in_run && osc_ok;
   assign warm_fall  = warm_prev_q && !warm_req_n;
   assign warm_take  = warm_fall && host_rst_n && !supply_lost && !(|down_v);

   always_comb begin
      state_d = state_q;
      if (supply_lost)
         state_d = ST_NO_SUPPLY;
      else if (|down_v)
         state_d = ST_WAIT_ONOFF;
      else if (warm_take)
         state_d = ST_SEQ_ON;
      else begin
         unique case (state_q)
            ST_NO_SUPPLY:  state_d = ST_SEQ_ON;
            ST_WAIT_ONOFF: if (restart_q || on_req) state_d = ST_SEQ_ON;
            ST_SEQ_ON:     if (seq_done)  state_d = ST_ACTIVE;
            ST_ACTIVE:     if (sleep_req) state_d = ST_SLEEP;
            ST_SLEEP:      if (wake_req)  state_d = ST_ACTIVE;
            default:       state_d = ST_NO_SUPPLY;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_NO_SUPPLY;
         restart_q   <= 1'b0;
         warm_prev_q <= 1'b1;
         chg_q       <= 1'b0;
         reinit_q    <= 1'b0;
         reload_q    <= '0;
      end else begin
         state_q     <= state_d;
         warm_prev_q <= warm_req_n;
         reinit_q    <= warm_take;
         reload_q    <= warm_take ? ~keep_vsel : '0;

         if (supply_lost)
            restart_q <= 1'b0;
         else if (down_v[C_SOFT])
            restart_q <= 1'b1;
         else if (state_q == ST_WAIT_ONOFF)
            restart_q <= 1'b0;

         if (state_q == ST_NO_SUPPLY)
            chg_q <= 1'b0;
         else if (chg_hit)
            chg_q <= 1'b1;
      end
   end

   assign chg_rst_n   = chg_q;
   assign warm_reinit = reinit_q;
   assign vsel_reload = reload_q;
   assign pwr_state   = state_q;
endmodule

// File: rtl/pwr_rst_seq_chk.sv
module pwr_rst_seq_chk #(
   parameter int N_RES        = 4,
   parameter bit HAS_OSC_GATE = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             main_batt_low,
   input logic             bkup_batt_low,
   input logic             osc_stable,
   input logic             osc_gate_en,
   input logic [3:0]       stat_clr,
   input logic             host_rst_n,
   input logic             chg_rst_n,
   input logic             warm_reinit,
   input logic [N_RES-1:0] vsel_reload,
   input logic [2:0]       pwr_state,
   input logic [3:0]       turnoff_stat
);
   localparam logic [2:0] S_NONE = 3'd0;
   localparam logic [2:0] S_SEQ  = 3'd2;
   localparam logic [2:0] S_ACT  = 3'd3;
   localparam logic [2:0] S_SLP  = 3'd4;

   assert_host_only_running_R10: assert property (@(posedge clk) disable iff (!rst_n)
      host_rst_n |-> (pwr_state == S_ACT || pwr_state == S_SLP));

   if (HAS_OSC_GATE) begin : g_osc
      assert_host_waits_osc_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (osc_gate_en && !osc_stable) |-> !host_rst_n);
   end

   assert_supply_loss_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (main_batt_low && bkup_batt_low) |=> (pwr_state == S_NONE));

   assert_charger_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == S_NONE) |=> !chg_rst_n);

   assert_stat_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|turnoff_stat) |=> ((turnoff_stat | $past(stat_clr)) & $past(turnoff_stat))
                          == $past(turnoff_stat));

   assert_reload_needs_warm_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|vsel_reload) |-> warm_reinit);

   assert_warm_after_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      warm_reinit |-> ($past(host_rst_n) && pwr_state == S_SEQ));
endmodule

bind pwr_rst_seq pwr_rst_seq_chk #(.N_RES(N_RES), .HAS_OSC_GATE(HAS_OSC_GATE)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .main_batt_low (main_batt_low),
   .bkup_batt_low (bkup_batt_low),
   .osc_stable    (osc_stable),
   .osc_gate_en   (osc_gate_en),
   .stat_clr      (stat_clr),
   .host_rst_n    (host_rst_n),
   .chg_rst_n     (chg_rst_n),
   .warm_reinit   (warm_reinit),
   .vsel_reload   (vsel_reload),
   .pwr_state     (pwr_state),
   .turnoff_stat  (turnoff_stat)
);

// File: tb/pwr_rst_seq_tb.sv
module pwr_rst_seq_tb;
   localparam int CLK_P    = 10;
   localparam int SEQ_CYC  = 8;
   localparam int CHG_STEP = 3;
   localparam int KEY_SEC  = 10;
   localparam int N_RES    = 4;

   logic clk = 1'b0;
   logic rst_n, main_batt_low, bkup_batt_low, on_req, sw_cold_rst, key_held, tick_1hz;
   logic wdog_expired, therm_shut, warm_req_n, sleep_req, wake_req, osc_stable, osc_gate_en;
   logic [N_RES-1:0] keep_vsel;
   logic [3:0]       stat_clr;
   logic             host_rst_n, chg_rst_n, warm_reinit;
   logic [N_RES-1:0] vsel_reload;
   logic [2:0]       pwr_state;
   logic [3:0]       turnoff_stat;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   pwr_rst_seq #(.SEQ_CYC(SEQ_CYC), .CHG_STEP(CHG_STEP), .KEY_SEC(KEY_SEC),
                 .N_RES(N_RES), .HAS_OSC_GATE(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .main_batt_low(main_batt_low), .bkup_batt_low(bkup_batt_low),
      .on_req(on_req), .sw_cold_rst(sw_cold_rst), .key_held(key_held), .tick_1hz(tick_1hz),
      .wdog_expired(wdog_expired), .therm_shut(therm_shut), .warm_req_n(warm_req_n),
      .sleep_req(sleep_req), .wake_req(wake_req), .osc_stable(osc_stable),
      .osc_gate_en(osc_gate_en), .keep_vsel(keep_vsel), .stat_clr(stat_clr),
      .host_rst_n(host_rst_n), .chg_rst_n(chg_rst_n), .warm_reinit(warm_reinit),
      .vsel_reload(vsel_reload), .pwr_state(pwr_state), .turnoff_stat(turnoff_stat));

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   task automatic pulse_tick;
      tick_1hz = 1'b1; step(1); tick_1hz = 1'b0; step(1);
   endtask

   task automatic restart_from_wait;
      on_req = 1'b1; step(1); on_req = 1'b0;
      chk("R6", "state after on_req", pwr_state, 2);
      step(SEQ_CYC);
      chk("R2", "state after restart", pwr_state, 3);
   endtask

   task automatic t_reset;
      rst_n = 1'b0; main_batt_low = 1'b1; bkup_batt_low = 1'b1;
      step(3);
      chk("R1", "reset state", pwr_state, 0);
      chk("R1", "reset host", host_rst_n, 0);
      chk("R3", "reset charger", chg_rst_n, 0);
      chk("R7", "reset stat", turnoff_stat, 0);
      rst_n = 1'b1; step(2);
      chk("R1", "state held by supply loss", pwr_state, 0);
   endtask

   task automatic t_boot;
      main_batt_low = 1'b0; bkup_batt_low = 1'b0;
      step(1);
      chk("R2", "state enters sequencing", pwr_state, 2);
      chk("R3", "charger early", chg_rst_n, 0);
      step(CHG_STEP);
      chk("R3", "charger before release edge", chg_rst_n, 0);
      step(1);
      chk("R3", "charger released", chg_rst_n, 1);
      chk("R3", "host still held", host_rst_n, 0);
      step(SEQ_CYC - CHG_STEP - 2);
      chk("R2", "state last sequencing cycle", pwr_state, 2);
      step(1);
      chk("R2", "state active", pwr_state, 3);
      chk("R10", "host released", host_rst_n, 1);
   endtask

   task automatic t_long_key;
      key_held = 1'b1;
      for (int i = 0; i < KEY_SEC - 1; i++) pulse_tick();
      chk("R5", "short hold keeps active", pwr_state, 3);
      key_held = 1'b0; step(1); key_held = 1'b1;
      for (int i = 0; i < KEY_SEC - 1; i++) pulse_tick();
      chk("R5", "count restarted after release", pwr_state, 3);
      pulse_tick();
      chk("R5", "long hold shuts down", pwr_state, 1);
      chk("R7", "key cause bit", turnoff_stat, 4'b0001);
      key_held = 1'b0;
   endtask

   task automatic t_w1c_key;
      stat_clr = 4'b0001; step(1); stat_clr = 4'b0000;
      chk("R7", "key bit cleared", turnoff_stat, 0);
      chk("R6", "wait held without on_req", pwr_state, 1);
      restart_from_wait();
   endtask

   task automatic t_wdog_therm;
      wdog_expired = 1'b1; therm_shut = 1'b1; step(1);
      wdog_expired = 1'b0; therm_shut = 1'b0;
      chk("R6", "watchdog+thermal shut down", pwr_state, 1);
      chk("R7", "both causes recorded", turnoff_stat, 4'b0110);
      stat_clr = 4'b0010; step(1); stat_clr = 4'b0000;
      chk("R7", "partial clear", turnoff_stat, 4'b0100);
      wdog_expired = 1'b1; step(1); wdog_expired = 1'b0;
      chk("R6", "cause in wait not recorded", turnoff_stat, 4'b0100);
      chk("R6", "cause in wait keeps state", pwr_state, 1);
      stat_clr = 4'b1111; step(1); stat_clr = 4'b0000;
      chk("R7", "full clear", turnoff_stat, 0);
      restart_from_wait();
      therm_shut = 1'b1; stat_clr = 4'b0100; step(1);
      therm_shut = 1'b0; stat_clr = 4'b0000;
      chk("R7", "set wins over clear", turnoff_stat, 4'b0100);
      stat_clr = 4'b0100; step(1); stat_clr = 4'b0000;
      restart_from_wait();
   endtask

   task automatic t_soft;
      sw_cold_rst = 1'b1; step(1); sw_cold_rst = 1'b0;
      chk("R4", "soft restart to wait", pwr_state, 1);
      chk("R7", "soft cause bit", turnoff_stat, 4'b1000);
      step(1);
      chk("R4", "automatic switch-on", pwr_state, 2);
      step(SEQ_CYC);
      chk("R4", "back to active", pwr_state, 3);
      stat_clr = 4'b1000; step(1); stat_clr = 4'b0000;
   endtask

   task automatic t_warm;
      keep_vsel = 4'b0101;
      warm_req_n = 1'b0; step(1);
      chk("R8", "warm restarts sequence", pwr_state, 2);
      chk("R8", "reinit pulse", warm_reinit, 1);
      chk("R8", "reload mask", vsel_reload, 4'b1010);
      chk("R8", "stat untouched", turnoff_stat, 0);
      chk("R8", "charger untouched", chg_rst_n, 1);
      warm_req_n = 1'b1; step(1);
      chk("R8", "reinit single cycle", warm_reinit, 0);
      chk("R8", "reload cleared", vsel_reload, 0);
      warm_req_n = 1'b0; step(1);
      chk("R9", "warm ignored in sequencing", pwr_state, 2);
      chk("R9", "no reinit in sequencing", warm_reinit, 0);
      warm_req_n = 1'b1;
      step(SEQ_CYC - 2);
      chk("R8", "active after warm sequence", pwr_state, 3);
   endtask

   task automatic t_osc_gate;
      osc_gate_en = 1'b1; osc_stable = 1'b0; step(1);
      chk("R10", "host held for oscillator", host_rst_n, 0);
      chk("R10", "state still active", pwr_state, 3);
      warm_req_n = 1'b0; step(1); warm_req_n = 1'b1;
      chk("R9", "warm ignored while host held", pwr_state, 3);
      chk("R9", "no reinit while host held", warm_reinit, 0);
      osc_stable = 1'b1; step(1);
      chk("R10", "host released on stable osc", host_rst_n, 1);
      osc_gate_en = 1'b0; step(1);
   endtask

   task automatic t_sleep;
      sleep_req = 1'b1; step(1); sleep_req = 1'b0;
      chk("R11", "enter sleep", pwr_state, 4);
      chk("R11", "host released in sleep", host_rst_n, 1);
      wake_req = 1'b1; step(1); wake_req = 1'b0;
      chk("R11", "wake to active", pwr_state, 3);
   endtask

   task automatic t_por_drop;
      main_batt_low = 1'b1; step(1);
      chk("R1", "single low battery ignored", pwr_state, 3);
      bkup_batt_low = 1'b1; step(1);
      chk("R1", "both low to no supply", pwr_state, 0);
      chk("R1", "host asserted", host_rst_n, 0);
      step(1);
      chk("R3", "charger asserted", chg_rst_n, 0);
      chk("R1", "stays in no supply", pwr_state, 0);
      t_boot();
   endtask

   initial begin
      #(CLK_P * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      on_req = 0; sw_cold_rst = 0; key_held = 0; tick_1hz = 0; wdog_expired = 0;
      therm_shut = 0; warm_req_n = 1; sleep_req = 0; wake_req = 0; osc_stable = 0;
      osc_gate_en = 0; keep_vsel = '0; stat_clr = '0;
      main_batt_low = 1; bkup_batt_low = 1; rst_n = 0;
      t_reset();
      t_boot();
      t_long_key();
      t_w1c_key();
      t_wdog_therm();
      t_soft();
      t_warm();
      t_osc_gate();
      t_sleep();
      t_por_drop();
      summary();
      $finish;
   end
endmodule